// File: doc/BRIEF.md
# Maskable Interrupt Controller Register Block

This block gathers a parameterised set of interrupt request lines (1 to 64), all synchronous to its clock, and latches each event into a status bit. A parameter vector decides for every line whether it is level-sensitive or edge-sensitive. A mask decides which latched bits may pull the single active-low interrupt output towards the host. Software sees the block as five consecutive word addresses on a simple synchronous register port.

The mask cannot be written directly. One strobe address sets mask bits and another clears them, so two agents can each change their own lines without a read-modify-write. A third strobe address acknowledges latched events. The status and mask words are read-only. The three strobe addresses read as zero.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, status and mask are all zero, `irq_n` is 1 and `reg_rdata` is zero.
- R2: The registers sit at fixed offsets from `BASE_ADDR`: +0 status (read-only), +1 mask (read-only), +2 set-mask strobe, +3 clear-mask strobe, +4 acknowledge strobe. `reg_rdata` shows the addressed word one cycle after `reg_rd` is high. It is zero in any cycle that follows one with `reg_rd` low.
- R3: When a line whose `SENSE` bit is 0 (level) is high at a clock edge, its status bit sets at that edge. If the line is still high after an acknowledge, the bit sets again on the next edge.
- R4: A line whose `SENSE` bit is 1 (edge) sets its status bit only on a 0-to-1 change between consecutive samples. Holding the line high after an acknowledge does not set the bit again.
- R5: Writing to +2 sets every mask bit that is 1 in `reg_wdata`. Bits written as 0 keep their value.
- R6: Writing to +3 clears every mask bit that is 1 in `reg_wdata`. Bits written as 0 keep their value.
- R7: Writing to +4 clears every status bit that is 1 in `reg_wdata`. Bits written as 0 keep their value.
- R8: When a set event and an acknowledge of the same bit fall in the same cycle, the status bit stays 1.
- R9: `irq_n` is 0 exactly one cycle after a cycle in which some bit is 1 in both status and mask. Otherwise it is 1.
- R10: Reads of +2, +3 and +4 return zero. Reads and writes at addresses outside +0..+4 change nothing, and such reads return zero.
- R11: Writes to the status or mask address change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all interrupt lines are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | NUM_IRQ | Interrupt request lines |
| reg_addr | input | ADDR_W | Register port word address |
| reg_wr | input | 1 | Write enable for the current cycle |
| reg_wdata | input | NUM_IRQ | Write data |
| reg_rd | input | 1 | Read enable; data follows one cycle later |
| reg_rdata | output | NUM_IRQ | Registered read data |
| irq_n | output | 1 | Active-low registered interrupt to the host |

## Verification
The collision that matters is a new set event and an acknowledge of the same status bit landing on the same clock edge. The bench causes it in two ways. It acknowledges a level line while that line is still held high. It also raises an edge line in the very cycle it writes the acknowledge for that bit. Each time, the read of status that follows must still show the bit. A second pass acknowledges the held edge line on a later cycle, and that read must show the bit cleared. A sweep over all 256 input patterns mixes mask strobes and acknowledges with the input changes and compares every read and every `irq_n` sample against an arithmetic model.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_MASK   = 1;
  localparam int unsigned OFS_SET    = 2;
  localparam int unsigned OFS_CLR    = 3;
  localparam int unsigned OFS_ACK    = 4;
  localparam int unsigned NUM_REGS   = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_SET,
    SEL_CLR,
    SEL_ACK
  } reg_sel_e;
endpackage

// File: rtl/irq_line_detect.sv
`timescale 1ns/1ps
module irq_line_detect #(
  parameter int unsigned NUM_IRQ = 8,
  parameter logic [NUM_IRQ-1:0] SENSE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] set_ev
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    if (SENSE[i]) begin : g_edge
      logic prev_q;
      logic prev_d;

      always_comb prev_d = irq_in[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
      end

      always_comb set_ev[i] = irq_in[i] & ~prev_q;

      // an edge event needs the line to have been low on the previous cycle
      AST_EDGE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && set_ev[i]) |-> !$past(irq_in[i])); // R4
    end else begin : g_level
      always_comb set_ev[i] = irq_in[i];
    end
  end
endmodule

// File: rtl/irq_status_mask.sv
`timescale 1ns/1ps
module irq_status_mask #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] set_ev,
  input  logic [NUM_IRQ-1:0] ack_bits,
  input  logic [NUM_IRQ-1:0] en_bits,
  input  logic [NUM_IRQ-1:0] dis_bits,
  output logic [NUM_IRQ-1:0] status_q,
  output logic [NUM_IRQ-1:0] mask_q
);
  logic [NUM_IRQ-1:0] status_d;
  logic [NUM_IRQ-1:0] mask_d;
  logic               status_ce;
  logic               mask_ce;

  always_comb begin
    status_ce = |set_ev | |ack_bits;
    mask_ce   = |en_bits | |dis_bits;
    // a set in the same cycle overrides the acknowledge
    status_d  = (status_q & ~ack_bits) | set_ev;
    mask_d    = (mask_q | en_bits) & ~dis_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      if (status_ce) status_q <= status_d;
      if (mask_ce)   mask_q   <= mask_d;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(ack_bits & ~set_ev)) == '0)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_ev) & ~status_q) == '0)); // R8
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(en_bits) & ~mask_q) == '0)); // R5
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(dis_bits) & mask_q) == '0)); // R6
endmodule

// File: rtl/irq_regport.sv
`timescale 1ns/1ps
module irq_regport
  import irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [NUM_IRQ-1:0] reg_wdata,
  input  logic               reg_rd,
  input  logic [NUM_IRQ-1:0] status_q,
  input  logic [NUM_IRQ-1:0] mask_q,
  output logic [NUM_IRQ-1:0] en_bits,
  output logic [NUM_IRQ-1:0] dis_bits,
  output logic [NUM_IRQ-1:0] ack_bits,
  output logic [NUM_IRQ-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(BASE_ADDR + OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(BASE_ADDR + OFS_MASK);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(BASE_ADDR + OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(BASE_ADDR + OFS_CLR);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(BASE_ADDR + OFS_ACK);

  reg_sel_e           sel;
  logic [NUM_IRQ-1:0] rdata_d;

  always_comb begin
    unique case (reg_addr)
      A_STATUS: sel = SEL_STATUS;
      A_MASK:   sel = SEL_MASK;
      A_SET:    sel = SEL_SET;
      A_CLR:    sel = SEL_CLR;
      A_ACK:    sel = SEL_ACK;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    en_bits  = (reg_wr && sel == SEL_SET) ? reg_wdata : '0;
    dis_bits = (reg_wr && sel == SEL_CLR) ? reg_wdata : '0;
    ack_bits = (reg_wr && sel == SEL_ACK) ? reg_wdata : '0;
  end

  always_comb begin
    rdata_d = '0;
    if (reg_rd) begin
      case (sel)
        SEL_STATUS: rdata_d = status_q;
        SEL_MASK:   rdata_d = mask_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rdata_d;
  end

  AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel != SEL_STATUS && sel != SEL_MASK) |=> (reg_rdata == '0)); // R10
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|en_bits, |dis_bits, |ack_bits}) <= 1); // R10
endmodule

// File: rtl/irq_mask_ctrl.sv
`timescale 1ns/1ps
module irq_mask_ctrl #(
  parameter int unsigned        NUM_IRQ   = 8,
  parameter int unsigned        ADDR_W    = 8,
  parameter int unsigned        BASE_ADDR = 16,
  parameter logic [NUM_IRQ-1:0] SENSE     = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [NUM_IRQ-1:0] reg_wdata,
  input  logic               reg_rd,
  output logic [NUM_IRQ-1:0] reg_rdata,
  output logic               irq_n
);
  logic [NUM_IRQ-1:0] set_ev;
  logic [NUM_IRQ-1:0] status_q;
  logic [NUM_IRQ-1:0] mask_q;
  logic [NUM_IRQ-1:0] en_bits;
  logic [NUM_IRQ-1:0] dis_bits;
  logic [NUM_IRQ-1:0] ack_bits;
  logic               irq_n_d;

  irq_line_detect #(.NUM_IRQ(NUM_IRQ), .SENSE(SENSE)) i_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .set_ev(set_ev)
  );

  irq_status_mask #(.NUM_IRQ(NUM_IRQ)) i_state (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .ack_bits(ack_bits),
    .en_bits(en_bits), .dis_bits(dis_bits),
    .status_q(status_q), .mask_q(mask_q)
  );

  irq_regport #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .status_q(status_q),
    .mask_q(mask_q), .en_bits(en_bits), .dis_bits(dis_bits),
    .ack_bits(ack_bits), .reg_rdata(reg_rdata)
  );

  always_comb irq_n_d = ~|(status_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= irq_n_d;
  end

  AST_IRQ_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && |(status_q & mask_q)) |=> !irq_n); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q) == '0) |=> irq_n); // R9
endmodule

// File: tb/test_irq_mask_ctrl.sv
`timescale 1ns/1ps
module test_irq_mask_ctrl;
  localparam int unsigned N    = 8;
  localparam int unsigned AW   = 8;
  localparam int unsigned BASE = 16;
  localparam logic [N-1:0] SNS = 8'hF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [N-1:0]  reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [N-1:0]  reg_rdata;
  logic          irq_n;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // model state
  logic [N-1:0] m_status, m_mask, m_prev;
  logic         m_irqn;
  logic [N-1:0] t_set, t_ack, t_en, t_dis;

  irq_mask_ctrl #(.NUM_IRQ(N), .ADDR_W(AW), .BASE_ADDR(BASE), .SENSE(SNS)) i_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status = '0; m_mask = '0; m_prev = '0; m_irqn = 1'b1;
    end else begin
      t_set = (irq_in & ~SNS) | (irq_in & ~m_prev & SNS);
      t_ack = (reg_wr && reg_addr == AW'(BASE + 4)) ? reg_wdata : '0;
      t_en  = (reg_wr && reg_addr == AW'(BASE + 2)) ? reg_wdata : '0;
      t_dis = (reg_wr && reg_addr == AW'(BASE + 3)) ? reg_wdata : '0;
      m_irqn   = ((m_status & m_mask) == '0);
      m_status = (m_status & ~t_ack) | t_set;
      m_mask   = (m_mask | t_en) & ~t_dis;
      m_prev   = irq_in;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [N-1:0] d);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input int unsigned a, input logic [N-1:0] exp, input string tag);
    reg_addr = AW'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rdata, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({7'd0, irq_n}, 8'h01, "R1 irq_n in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata, 8'h00, "R1 rdata after reset");
    rd_chk(BASE, 8'h00, "R1 status after reset");
    rd_chk(BASE + 1, 8'h00, "R1 mask after reset");
    @(negedge clk);
    chk(reg_rdata, 8'h00, "R2 rdata zero when no read");

    // mask strobes
    wr(BASE + 2, 8'h0F);
    rd_chk(BASE + 1, 8'h0F, "R5 set-mask strobe");
    wr(BASE + 2, 8'h00);
    rd_chk(BASE + 1, 8'h0F, "R5 zeros leave mask");
    wr(BASE + 3, 8'h03);
    rd_chk(BASE + 1, 8'h0C, "R6 clear-mask strobe");
    wr(BASE + 3, 8'h00);
    rd_chk(BASE + 1, 8'h0C, "R6 zeros leave mask");

    // read-only and out-of-window
    wr(BASE, 8'hFF);
    wr(BASE + 1, 8'hFF);
    rd_chk(BASE + 1, 8'h0C, "R11 mask write ignored");
    rd_chk(BASE, 8'h00, "R11 status write ignored");
    wr(BASE + 5, 8'hFF);
    wr(BASE - 1, 8'hFF);
    rd_chk(BASE + 1, 8'h0C, "R10 outside write ignored");
    rd_chk(BASE + 2, 8'h00, "R10 set strobe reads zero");
    rd_chk(BASE + 3, 8'h00, "R10 clear strobe reads zero");
    rd_chk(BASE + 4, 8'h00, "R10 ack strobe reads zero");
    rd_chk(BASE + 5, 8'h00, "R10 outside read zero");
    chk({7'd0, irq_n}, 8'h01, "R9 idle irq_n high");

    // level line 2 (masked on)
    irq_in = 8'h04;
    @(negedge clk);
    chk({7'd0, irq_n}, 8'h01, "R9 irq_n one cycle after status");
    @(negedge clk);
    chk({7'd0, irq_n}, 8'h00, "R9 irq_n low");
    rd_chk(BASE, 8'h04, "R3 level latched");
    wr(BASE + 4, 8'h04);
    rd_chk(BASE, 8'h04, "R8 R3 level held through ack");
    irq_in = 8'h00;
    wr(BASE + 4, 8'h00);
    rd_chk(BASE, 8'h04, "R7 zero ack no effect");
    wr(BASE + 4, 8'h04);
    rd_chk(BASE, 8'h00, "R7 ack clears");
    @(negedge clk);
    chk({7'd0, irq_n}, 8'h01, "R9 irq_n released");

    // edge line 5
    irq_in = 8'h20;
    @(negedge clk);
    rd_chk(BASE, 8'h20, "R4 edge latched");
    wr(BASE + 4, 8'h20);
    rd_chk(BASE, 8'h00, "R4 held edge line no relatch");
    chk({7'd0, irq_n}, 8'h01, "R9 unmasked line keeps irq_n high");
    irq_in = 8'h00;
    @(negedge clk);
    // rising edge in the same cycle as its ack
    irq_in = 8'h20;
    wr(BASE + 4, 8'h20);
    rd_chk(BASE, 8'h20, "R8 edge set beats ack");
    irq_in = 8'h00;
    wr(BASE + 4, 8'hFF);
    rd_chk(BASE, 8'h00, "R7 all cleared");

    // sweep all input patterns, model compared
    for (int p = 0; p < 256; p++) begin
      irq_in = 8'(p);
      if (p % 3 == 0) wr(BASE + 2, 8'(p * 7));
      else if (p % 3 == 1) wr(BASE + 3, 8'(p * 5));
      else @(negedge clk);
      chk({7'd0, irq_n}, {7'd0, m_irqn}, "R9 sweep irq_n");
      rd_chk(BASE, m_status, "R3 R4 sweep status");
      wr(BASE + 4, 8'(p ^ 8'h5A));
      rd_chk(BASE + 1, m_mask, "R5 R6 sweep mask");
      chk({7'd0, irq_n}, {7'd0, m_irqn}, "R9 sweep irq_n after ack");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule